// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a 32-pin general-purpose I/O port that sits behind a plain 32-bit register bus. Software sets each pin to input or output, picks push-pull or open-drain drive per pin, and writes an output latch. The block turns that state into three per-pin pad controls: output value, output enable and an open-drain marker. The pad inputs pass through a two-flop synchroniser. The synchronised values feed register reads and are also brought out for a separate event or interrupt block.

In every register, pin numbers run from the most significant bit down. A build option makes the four highest-numbered pins permanently input-only. The data register returns a mix: output pins read back their latch and input pins read back their synchronised pad. Writes to the latch always take effect, so a pin that is still an input can be preset before it is turned into an output.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Out of reset the direction, open-drain and latch registers all read 0, and `pad_oe` and `pad_od` are 0 for every pin.
- R2: Pin n corresponds to register bit (31 - n) in the direction (offset 0x00), open-drain (offset 0x04) and data (offset 0x08) registers, and to index n of every pad vector.
- R3: A direction bit of 1 makes the pin an output and 0 makes it an input. An input pin has `pad_oe` = 0 and `pad_od` = 0. The new direction reaches the pads on the clock edge that takes the write.
- R4: For an output pin whose open-drain bit is clear, `pad_oe` = 1 and `pad_out` equals the latch. For an output pin whose open-drain bit is set, `pad_od` = 1 and `pad_out` = 0, and `pad_oe` = 1 only while the latch is 0, so a latch value of 1 releases the pad.
- R5: A read of the data register returns (sync_pad & ~dir) | (latch & dir) in register bit order.
- R6: A write to the data register updates the latch for every pin, inputs included. A later switch of that pin to output drives the preset value starting on the same edge as the switch.
- R7: When `HIGH_PINS_INPUT_ONLY` is 1, pins 28 to 31 (register bits 3 to 0) can never be outputs. Their direction bits read 0 after a write of 1, and their `pad_oe` and `pad_od` stay 0.
- R8: A change on `pad_in` shows on `pin_sync` two clock edges later and not earlier.
- R9: A read of any offset other than 0x00, 0x04 or 0x08 returns 0. A write to such an offset changes no register.
- R10: `bus_rdata` is registered. It carries the read result in the cycle after `bus_rd` is high and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPIN | Raw pad input, index = pin number |
| pad_out | output | NPIN | Pad output value, index = pin number |
| pad_oe | output | NPIN | Pad output enable, index = pin number |
| pad_od | output | NPIN | Open-drain marker for output pins, index = pin number |
| pin_sync | output | NPIN | Synchronised pad input for the event block |

## Verification
On every cycle the assertions check the following:
- no pin ever drives a 1 while it is marked open-drain;
- the locked high pins never get an output enable;
- a direction write appears on the pad controls in bit-reversed order one edge later;
- `pin_sync` lags `pad_in` by exactly two edges;
- read data is 0 after idle cycles and after unmapped reads.

Only the bench's scenarios can show the rest:
- the mixed read-back of the data register;
- that the latch keeps a value preset on an input pin;
- that writes to unmapped offsets leave the registers unchanged;
- the full pad encoding for random mixes of direction, open-drain and latch values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int REG_W = 32;

   localparam logic [7:0] OFS_DIR = 8'h00;
   localparam logic [7:0] OFS_ODS = 8'h04;
   localparam logic [7:0] OFS_DAT = 8'h08;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_ODS  = 2'd2,
      SEL_DAT  = 2'd3
   } reg_sel_e;

   // Register bits backed by an existing pin: pin n lives at bit (31 - n).
   function automatic logic [REG_W-1:0] impl_mask(int npin);
      logic [REG_W-1:0] m;
      m = '0;
      for (int n = 0; n < REG_W; n++)
         if (n < npin) m[REG_W-1-n] = 1'b1;
      return m;
   endfunction

   // Register bits whose direction may be set to output.
   function automatic logic [REG_W-1:0] dir_mask(int npin, bit lock_en, int nlock);
      logic [REG_W-1:0] m;
      m = impl_mask(npin);
      if (lock_en)
         for (int n = 0; n < REG_W; n++)
            if (n < npin && n >= npin - nlock) m[REG_W-1-n] = 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W               = 8,
   parameter int NPIN                 = 32,
   parameter bit HIGH_PINS_INPUT_ONLY = 1'b0,
   parameter int NUM_INPUT_ONLY       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output reg_sel_e          sel,
   output logic [REG_W-1:0]  dir_q,
   output logic [REG_W-1:0]  ods_q,
   output logic [REG_W-1:0]  lat_q
);

   localparam logic [REG_W-1:0] IMPL_M = impl_mask(NPIN);
   localparam logic [REG_W-1:0] DIR_M  = dir_mask(NPIN, HIGH_PINS_INPUT_ONLY, NUM_INPUT_ONLY);

   always_comb begin
      if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
      else if (addr == ADDR_W'(OFS_ODS)) sel = SEL_ODS;
      else if (addr == ADDR_W'(OFS_DAT)) sel = SEL_DAT;
      else                               sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         ods_q <= '0;
         lat_q <= '0;
      end else if (wr) begin
         case (sel)
            SEL_DIR: dir_q <= wdata & DIR_M;
            SEL_ODS: ods_q <= wdata & IMPL_M;
            SEL_DAT: lat_q <= wdata & IMPL_M;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
   import gpio_port_pkg::*;
#(
   parameter int NPIN = 32
) (
   input  logic [REG_W-1:0] dir_q,
   input  logic [REG_W-1:0] ods_q,
   input  logic [REG_W-1:0] lat_q,
   output logic [NPIN-1:0]  pad_out,
   output logic [NPIN-1:0]  pad_oe,
   output logic [NPIN-1:0]  pad_od
);

   for (genvar n = 0; n < NPIN; n++) begin : g_pin
      localparam int B = REG_W - 1 - n;
      always_comb begin
         pad_od[n]  = dir_q[B] & ods_q[B];
         pad_out[n] = lat_q[B] & ~ods_q[B];
         pad_oe[n]  = dir_q[B] & (ods_q[B] ? ~lat_q[B] : 1'b1);
      end
   end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
   import gpio_port_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  reg_sel_e         sel,
   input  logic [REG_W-1:0] dir_q,
   input  logic [REG_W-1:0] ods_q,
   input  logic [REG_W-1:0] lat_q,
   input  logic [REG_W-1:0] sync_q,
   output logic [REG_W-1:0] rdata
);

   logic [REG_W-1:0] data_view;
   assign data_view = (sync_q & ~dir_q) | (lat_q & dir_q);

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) begin
         case (sel)
            SEL_DIR: rdata <= dir_q;
            SEL_ODS: rdata <= ods_q;
            SEL_DAT: rdata <= data_view;
            default: rdata <= '0;
         endcase
      end else     rdata <= '0;
   end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int ADDR_W               = 8,
   parameter int NPIN                 = 32,
   parameter bit HIGH_PINS_INPUT_ONLY = 1'b0,
   parameter int NUM_INPUT_ONLY       = 4,
   parameter int SYNC_STAGES          = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN-1:0]   pad_od,
   output logic [NPIN-1:0]   pin_sync
);

   if (NPIN < 1 || NPIN > REG_W) begin : g_bad_npin
      $error("gpio_port_ctrl: NPIN must lie in 1..32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_port_ctrl: ADDR_W must be at least 4");
   end
   if (HIGH_PINS_INPUT_ONLY && (NUM_INPUT_ONLY < 0 || NUM_INPUT_ONLY > NPIN)) begin : g_bad_lock
      $error("gpio_port_ctrl: NUM_INPUT_ONLY out of range");
   end

   reg_sel_e         sel;
   logic [REG_W-1:0] dir_q, ods_q, lat_q, sync_q;

   gpio_port_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   // Synchronised pins placed in register bit order.
   always_comb begin
      sync_q = '0;
      for (int n = 0; n < NPIN; n++) sync_q[REG_W-1-n] = pin_sync[n];
   end

   gpio_port_regs #(
      .ADDR_W(ADDR_W), .NPIN(NPIN),
      .HIGH_PINS_INPUT_ONLY(HIGH_PINS_INPUT_ONLY), .NUM_INPUT_ONLY(NUM_INPUT_ONLY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
      .sel(sel), .dir_q(dir_q), .ods_q(ods_q), .lat_q(lat_q)
   );

   gpio_port_pads #(.NPIN(NPIN)) u_pads (
      .dir_q(dir_q), .ods_q(ods_q), .lat_q(lat_q),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
   );

   gpio_port_rdmux u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel),
      .dir_q(dir_q), .ods_q(ods_q), .lat_q(lat_q), .sync_q(sync_q),
      .rdata(bus_rdata)
   );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int ADDR_W               = 8,
   parameter int NPIN                 = 32,
   parameter bit HIGH_PINS_INPUT_ONLY = 1'b0,
   parameter int NUM_INPUT_ONLY       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic [NPIN-1:0]   pad_in,
   input logic [NPIN-1:0]   pad_out,
   input logic [NPIN-1:0]   pad_oe,
   input logic [NPIN-1:0]   pad_od,
   input logic [NPIN-1:0]   pin_sync
);

   logic [NPIN-1:0] lock_pins, exp_dir_pins;
   logic            addr_dir, addr_mapped;
   logic [1:0]      since_rst;

   always_comb begin
      lock_pins    = '0;
      exp_dir_pins = '0;
      for (int n = 0; n < NPIN; n++) begin
         lock_pins[n]    = HIGH_PINS_INPUT_ONLY && (n >= NPIN - NUM_INPUT_ONLY);
         exp_dir_pins[n] = bus_wdata[31-n] && !lock_pins[n];
      end
   end

   assign addr_dir    = (bus_addr == ADDR_W'(8'h00));
   assign addr_mapped = addr_dir || (bus_addr == ADDR_W'(8'h04)) || (bus_addr == ADDR_W'(8'h08));

   always_ff @(posedge clk) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 2) since_rst <= since_rst + 2'd1;
   end

   // R1: pads idle on the first cycle out of reset
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_od == '0));

   // R3 and R2: direction write reaches the pad controls in bit-reversed order
   assert_dir_to_pads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && addr_dir) |=> ((pad_oe | pad_od) == $past(exp_dir_pins)));

   // R4: an open-drain pin never drives high
   assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & pad_oe & pad_out) == '0);

   // R7: locked pins never become outputs
   assert_locked_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_od) & lock_pins) == '0);

   // R8: two-edge synchroniser latency
   assert_sync_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

   // R9: unmapped read returns zero
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !addr_mapped) |=> (bus_rdata == 32'd0));

   // R10: read data is zero after an idle cycle
   assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 32'd0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
   .ADDR_W(ADDR_W), .NPIN(NPIN),
   .HIGH_PINS_INPUT_ONLY(HIGH_PINS_INPUT_ONLY), .NUM_INPUT_ONLY(NUM_INPUT_ONLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
   .pin_sync(pin_sync)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

   localparam int NP = 32;
   localparam logic [31:0] DIR_WR_MASK = 32'hFFFF_FFF0;  // pins 28..31 locked

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_od, pin_sync;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] m_dir = '0, m_ods = '0, m_lat = '0;

   always #4 clk = ~clk;  // 125 MHz

   gpio_port_ctrl #(.ADDR_W(8), .NPIN(NP), .HIGH_PINS_INPUT_ONLY(1'b1), .NUM_INPUT_ONLY(4))
   i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
      .pin_sync(pin_sync)
   );

   function automatic logic [31:0] to_reg(logic [NP-1:0] p);  // R2 mapping
      logic [31:0] r;
      for (int n = 0; n < NP; n++) r[31-n] = p[n];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic check_pads(string req);
      logic [NP-1:0] e_oe, e_out, e_od;
      for (int n = 0; n < NP; n++) begin
         e_od[n]  = m_dir[31-n] & m_ods[31-n];
         e_out[n] = m_lat[31-n] & ~m_ods[31-n];
         e_oe[n]  = m_dir[31-n] & (m_ods[31-n] ? ~m_lat[31-n] : 1'b1);
      end
      chk({req, " pad_oe"}, pad_oe, e_oe);
      chk({req, " pad_out"}, pad_out, e_out);
      chk({req, " pad_od"}, pad_od, e_od);
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         8'h00: m_dir = d & DIR_WR_MASK;
         8'h04: m_ods = d;
         8'h08: m_lat = d;
         default: ;
      endcase
   endtask

   function automatic logic [31:0] model_read(logic [7:0] a);
      case (a)
         8'h00: return m_dir;
         8'h04: return m_ods;
         8'h08: return (to_reg(pad_in) & ~m_dir) | (m_lat & m_dir);  // R5
         default: return 32'd0;
      endcase
   endfunction

   task automatic bus_read_check(string req, logic [7:0] a);
      logic [31:0] e;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      e = model_read(a);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, e);
   endtask

   task automatic set_pads(logic [NP-1:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] addrs [8];
      void'($urandom(32'h1357_9bdf));
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h02, 8'h3C, 8'hFF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 oe", pad_oe, '0);
      chk("R1 od", pad_od, '0);
      bus_read_check("R1 dir", 8'h00);
      bus_read_check("R1 ods", 8'h04);
      bus_read_check("R1 dat", 8'h08);

      // R8 synchroniser latency
      @(negedge clk); pad_in = 32'h0000_0005;
      @(negedge clk); chk("R8 one edge", pin_sync, 32'h0);
      @(negedge clk); chk("R8 two edges", pin_sync, 32'h0000_0005);

      // R2 bit order: pin 0 = MSB
      set_pads(32'h0000_0001);
      bus_read_check("R2 pin0 msb", 8'h08);
      chk("R2 expect", to_reg(pad_in), 32'h8000_0000);

      // R6 preset latch on an input pin, then switch to output
      bus_write(8'h08, 32'h8000_0000);
      chk("R6 still input", {31'd0, pad_oe[0]}, 32'd0);
      bus_write(8'h00, 32'h8000_0000);
      chk("R6 drives preset oe", {31'd0, pad_oe[0]}, 32'd1);
      chk("R6 drives preset out", {31'd0, pad_out[0]}, 32'd1);

      // R3 direction and R4 open-drain on pin 1
      bus_write(8'h04, 32'h4000_0000);
      bus_write(8'h00, 32'hC000_0000);
      bus_write(8'h08, 32'h4000_0000);
      check_pads("R4 od latch1 released");
      bus_write(8'h08, 32'h0000_0000);
      check_pads("R4 od latch0 pulls low");
      bus_write(8'h00, 32'h0000_0000);
      check_pads("R3 back to inputs");

      // R7 locked pins
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read_check("R7 dir reads locked zero", 8'h00);
      chk("R7 oe high pins", {28'd0, pad_oe[31:28]}, 32'd0);

      // R9 unmapped write ignored and read zero
      bus_write(8'h0C, 32'h1234_5678);
      bus_write(8'h01, 32'h0000_0000);
      bus_read_check("R9 dir kept", 8'h00);
      bus_read_check("R9 ods kept", 8'h04);
      bus_read_check("R9 unmapped read", 8'h0C);
      check_pads("R9 pads kept");

      // R10 idle after read
      bus_read_check("R10 read", 8'h00);
      @(negedge clk);
      chk("R10 idle zero", bus_rdata, 32'd0);

      // R5 mixed data view, random
      for (int i = 0; i < 300; i++) begin
         logic [7:0] a;
         a = addrs[$urandom_range(0, 7)];
         bus_write(a, $urandom());
         check_pads("R4 random pads");
         set_pads($urandom());
         bus_read_check("R5 random read", addrs[$urandom_range(0, 7)]);
         bus_read_check("R5 data view", 8'h08);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule